// File: doc/BRIEF.md
# Windowed Power-Good Delay Timer

This block turns four comparator flags on a regulator's feedback voltage into a delayed power-good indication. The four flags describe the two edges of the regulation window, each with its own rising and falling threshold:

- The lower edge has a set point above 92% of nominal and a clear point below 88%.
- The upper edge trips above 110.7% and releases below 107%.

All flags, and an active-high hold input, are synchronized into the clock domain. Hysteresis state is then kept for each window edge, giving a single in-window status. That status must be seen continuously for a short qualification interval before an internal good signal is raised. A long timer then runs while the internal good signal stays high and the hold input stays low. Power-good is released only when that timer completes.

The output models an open-drain pin. It is driven low, output high, whenever the rail is not good, the hold input is high, or the block is in reset. The clock frequency, the qualification time and the assertion delay are parameters, and the cycle counts are derived from them. A divisor parameter shrinks both counts for simulation.

Top module: `pgood_delay_timer`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `pg_pull_low` is 1. Reset clears all window state, filters and timers.
- R2: The lower window edge sets when the above-92% flag (`fb_gt_lo_rise`) is 1. It clears only when the above-88% flag (`fb_gt_lo_fall`) is 0. A rail that climbs from below 88% to between 88% and 92% therefore never counts as in window. A rail that falls from above 92% into that band stays in window.
- R3: The upper window edge trips when the above-110.7% flag (`fb_gt_hi_rise`) is 1. It releases only when the above-107% flag (`fb_gt_hi_fall`) is 0. A rail between 107% and 110.7% that came from above stays out of window.
- R4: The internal good signal rises only after the in-window status has been 1 for QUAL_CYC consecutive cycles. Any in-window stretch shorter than that starts no delay.
- R5: When the rail enters the window and stays there with `pg_hold` low, `pg_pull_low` falls exactly SYNC_STAGES+1+QUAL_CYC+DLY_CYC clock edges after the new flag values are first sampled.
- R6: Leaving the window, even for a single cycle, drives `pg_pull_low` to 1 within SYNC_STAGES+3 edges. The full qualification and delay must then elapse again after re-entry.
- R7: While `pg_hold` is 1, `pg_pull_low` is 1 whatever the flags are. It rises within SYNC_STAGES+1 edges of `pg_hold` going high.
- R8: A 1-to-0 transition of `pg_hold` with the rail qualified in window restarts the delay. `pg_pull_low` falls exactly SYNC_STAGES+DLY_CYC edges after the low hold value is first sampled.
- R9: A 1-to-0 transition of `pg_hold` while the rail is out of window starts no timing. The delay begins only when the window is later entered and qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_gt_lo_rise | input | 1 | Feedback above the lower-edge set threshold (92%) |
| fb_gt_lo_fall | input | 1 | Feedback above the lower-edge clear threshold (88%) |
| fb_gt_hi_rise | input | 1 | Feedback above the upper-edge trip threshold (110.7%) |
| fb_gt_hi_fall | input | 1 | Feedback above the upper-edge release threshold (107%) |
| pg_hold | input | 1 | Active-high hold; forces not-good and restarts the delay on release |
| pg_pull_low | output | 1 | 1 = open-drain power-good pin driven low (not good) |

## Verification
The bound checker watches, on every cycle:

- that each hysteresis state changes only on the threshold flag that is allowed to move it;
- that the internal good signal never rises before QUAL_CYC consecutive in-window cycles;
- that power-good is never released unless DLY_CYC consecutive qualified, unheld cycles preceded it;
- that hold, loss of window and reset each force the pin low on the next edge.

The exact release cycle after window entry and after hold release cannot be shown by those local properties. The same is true of how the two hysteresis bands respond to the direction from which the rail approaches, and of full restart after a one-cycle dropout. Only the bench's level sequences, compared cycle by cycle against its own window and age model, demonstrate those.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

   typedef struct packed {
      logic lo_rise;
      logic lo_fall;
      logic hi_rise;
      logic hi_fall;
   } pg_cmp_t;

   localparam int unsigned PG_CMP_W = $bits(pg_cmp_t);

   // Convert a time in microseconds to clock cycles, scaled down by div.
   function automatic int unsigned pg_us_to_cyc(
      input longint unsigned clk_hz,
      input longint unsigned us,
      input longint unsigned div
   );
      longint unsigned prod;
      prod = (clk_hz * us) / (64'd1_000_000 * div);
      return int'(prod);
   endfunction

   function automatic int unsigned pg_cnt_w(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/pg_flag_sync.sv
module pg_flag_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] chain [STAGES];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
            end
         end

         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pg_window_hyst.sv
module pg_window_hyst
   import pgood_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  pg_cmp_t cmp,
   output logic    lo_ok,
   output logic    over,
   output logic    in_win
);

   logic lo_ok_nx;
   logic over_nx;

   // Lower edge: set on the high threshold, clear only below the low one.
   always_comb begin
      lo_ok_nx = lo_ok;
      if (cmp.lo_rise)      lo_ok_nx = 1'b1;
      else if (!cmp.lo_fall) lo_ok_nx = 1'b0;
   end

   // Upper edge: trip on the high threshold, release only below the low one.
   always_comb begin
      over_nx = over;
      if (cmp.hi_rise)      over_nx = 1'b1;
      else if (!cmp.hi_fall) over_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_ok <= 1'b0;
         over  <= 1'b0;
      end else begin
         lo_ok <= lo_ok_nx;
         over  <= over_nx;
      end
   end

   assign in_win = lo_ok & ~over;

endmodule

// File: rtl/pg_qual_filter.sv
module pg_qual_filter
   import pgood_pkg::*;
#(
   parameter int unsigned QUAL_CYC = 25
) (
   input  logic clk,
   input  logic rst,
   input  logic in_win,
   output logic qual
);

   generate
      if (QUAL_CYC == 0) begin : g_bypass
         assign qual = in_win;
      end else begin : g_count
         localparam int unsigned CW = pg_cnt_w(QUAL_CYC);
         localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

         logic [CW-1:0] cnt;
         logic          qual_q;

         always_ff @(posedge clk) begin
            if (rst || !in_win) begin
               cnt    <= '0;
               qual_q <= 1'b0;
            end else if (!qual_q) begin
               if (cnt == LAST) qual_q <= 1'b1;
               else             cnt    <= cnt + 1'b1;
            end
         end

         assign qual = qual_q;
      end
   endgenerate

endmodule

// File: rtl/pg_assert_timer.sv
module pg_assert_timer
   import pgood_pkg::*;
#(
   parameter int unsigned DLY_CYC = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic qual,
   input  logic hold,
   output logic done
);

   localparam int unsigned CW = pg_cnt_w(DLY_CYC);
   localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !qual || hold) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         if (cnt == LAST) done <= 1'b1;
         else             cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/pgood_delay_timer.sv
module pgood_delay_timer
   import pgood_pkg::*;
#(
   parameter longint unsigned CLK_HZ      = 200_000_000,
   parameter longint unsigned QUAL_US     = 50,
   parameter longint unsigned DELAY_US    = 215_000,
   parameter longint unsigned SIM_DIV     = 1,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic fb_gt_lo_rise,
   input  logic fb_gt_lo_fall,
   input  logic fb_gt_hi_rise,
   input  logic fb_gt_hi_fall,
   input  logic pg_hold,
   output logic pg_pull_low
);

   localparam int unsigned QUAL_CYC = pg_us_to_cyc(CLK_HZ, QUAL_US, SIM_DIV);
   localparam int unsigned DLY_CYC  = pg_us_to_cyc(CLK_HZ, DELAY_US, SIM_DIV);
   localparam int unsigned SYNC_W   = PG_CMP_W + 1;

   generate
      if (SIM_DIV == 0) begin : g_bad_div
         $error("pgood_delay_timer: SIM_DIV must be nonzero");
      end
      if (DLY_CYC < 1) begin : g_bad_dly
         $error("pgood_delay_timer: delay rounds to zero cycles");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("pgood_delay_timer: SYNC_STAGES above 4 not supported");
      end
   endgenerate

   pg_cmp_t          cmp_raw;
   pg_cmp_t          cmp_s;
   logic             hold_s;
   logic [SYNC_W-1:0] sync_q;
   logic             lo_ok;
   logic             over;
   logic             in_win;
   logic             qual;
   logic             done;

   assign cmp_raw = '{lo_rise: fb_gt_lo_rise, lo_fall: fb_gt_lo_fall,
                      hi_rise: fb_gt_hi_rise, hi_fall: fb_gt_hi_fall};

   pg_flag_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({cmp_raw, pg_hold}),
      .q   (sync_q)
   );

   assign cmp_s  = pg_cmp_t'(sync_q[SYNC_W-1:1]);
   assign hold_s = sync_q[0];

   pg_window_hyst u_hyst (
      .clk    (clk),
      .rst    (rst),
      .cmp    (cmp_s),
      .lo_ok  (lo_ok),
      .over   (over),
      .in_win (in_win)
   );

   pg_qual_filter #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk    (clk),
      .rst    (rst),
      .in_win (in_win),
      .qual   (qual)
   );

   pg_assert_timer #(.DLY_CYC(DLY_CYC)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .qual (qual),
      .hold (hold_s),
      .done (done)
   );

   assign pg_pull_low = ~done;

endmodule

// File: rtl/pgood_delay_timer_chk.sv
module pgood_delay_timer_chk
   import pgood_pkg::*;
#(
   parameter int unsigned QUAL_CYC = 25,
   parameter int unsigned DLY_CYC  = 1000
) (
   input logic    clk,
   input logic    rst,
   input pg_cmp_t cmp_s,
   input logic    hold_s,
   input logic    lo_ok,
   input logic    over,
   input logic    in_win,
   input logic    qual,
   input logic    pg_pull_low
);

   localparam int unsigned QW = pg_cnt_w(QUAL_CYC);
   localparam int unsigned DW = pg_cnt_w(DLY_CYC);

   logic [QW-1:0] win_run;
   logic [DW-1:0] ok_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_run <= '0;
         ok_run  <= '0;
      end else begin
         if (!in_win)                       win_run <= '0;
         else if (win_run != QW'(QUAL_CYC)) win_run <= win_run + 1'b1;
         if (!qual || hold_s)               ok_run  <= '0;
         else if (ok_run != DW'(DLY_CYC))   ok_run  <= ok_run + 1'b1;
      end
   end

   AST_RESET_PULLS_LOW: assert property (@(posedge clk)
      rst |=> pg_pull_low); // R1

   AST_LO_SET_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(lo_ok) |-> $past(cmp_s.lo_rise)); // R2

   AST_LO_CLR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(lo_ok) |-> !$past(cmp_s.lo_fall)); // R2

   AST_HI_TRIP_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(over) |-> $past(cmp_s.hi_rise)); // R3

   AST_HI_REL_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(over) |-> !$past(cmp_s.hi_fall)); // R3

   AST_QUAL_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
      $rose(qual) |-> (win_run >= QW'(QUAL_CYC))); // R4

   AST_RELEASE_AFTER_DELAY: assert property (@(posedge clk) disable iff (rst)
      $fell(pg_pull_low) |-> (ok_run >= DW'(DLY_CYC))); // R5

   AST_NO_WINDOW_DROPS_QUAL: assert property (@(posedge clk) disable iff (rst)
      (!in_win && QUAL_CYC != 0) |=> !qual); // R6

   AST_NO_QUAL_PULLS_LOW: assert property (@(posedge clk) disable iff (rst)
      !qual |=> pg_pull_low); // R6

   AST_HOLD_PULLS_LOW: assert property (@(posedge clk) disable iff (rst)
      hold_s |=> pg_pull_low); // R7

endmodule

bind pgood_delay_timer pgood_delay_timer_chk #(
   .QUAL_CYC (QUAL_CYC),
   .DLY_CYC  (DLY_CYC)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cmp_s       (cmp_s),
   .hold_s      (hold_s),
   .lo_ok       (lo_ok),
   .over        (over),
   .in_win      (in_win),
   .qual        (qual),
   .pg_pull_low (pg_pull_low)
);

// File: tb/pgood_delay_timer_bench.sv
`timescale 1ns/1ps
module pgood_delay_timer_bench;

   localparam longint unsigned CLK_HZ   = 200_000_000;
   localparam longint unsigned QUAL_US  = 50;
   localparam longint unsigned DELAY_US = 2000;
   localparam longint unsigned SIM_DIV  = 400;
   localparam int SYNC = 2;
   localparam int DG   = int'(CLK_HZ / 1_000_000 * QUAL_US / SIM_DIV);   // 25
   localparam int DLY  = int'(CLK_HZ / 1_000_000 * DELAY_US / SIM_DIV);  // 1000
   localparam int LAT  = SYNC + 1 + DG + DLY;   // window entry to release
   localparam int KW   = SYNC + 2;              // window loss lag
   localparam int KH   = SYNC;                  // hold lag

   logic clk = 1'b0;
   logic rst = 1'b1;
   int   lvl = 0;      // 0:<88% 1:88-92% 2:92-107% 3:107-110.7% 4:>110.7%
   logic hold = 1'b0;
   logic pg_pull_low;

   always #2.5 clk = ~clk;

   pgood_delay_timer #(
      .CLK_HZ(CLK_HZ), .QUAL_US(QUAL_US), .DELAY_US(DELAY_US),
      .SIM_DIV(SIM_DIV), .SYNC_STAGES(SYNC)
   ) u_pgood_delay_timer (
      .clk           (clk),
      .rst           (rst),
      .fb_gt_lo_rise (lvl >= 2),
      .fb_gt_lo_fall (lvl >= 1),
      .fb_gt_hi_rise (lvl >= 4),
      .fb_gt_hi_fall (lvl >= 3),
      .pg_hold       (hold),
      .pg_pull_low   (pg_pull_low)
   );

   int    errors = 0;
   int    checks = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   // Inputs as seen at each rising edge.
   int   app_lvl;
   logic app_hold, app_rst;
   bit   started = 1'b0;
   always @(posedge clk) begin
      app_lvl  <= lvl;
      app_hold <= hold;
      app_rst  <= rst;
      started  <= 1'b1;
   end

   // Reference model from the requirements: hysteresis state plus ages.
   bit lo_st, hi_st;
   int win_age, hold_age;
   int wa [0:7];
   int ha [0:7];

   function automatic bit exp_pull_low(input int w_lag, input int h_lag);
      return !((w_lag >= LAT - KW) && (h_lag >= DLY));
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: pg_pull_low=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         logic e;
         if (app_rst) begin
            lo_st = 0; hi_st = 0; win_age = 0; hold_age = 0;
            for (int d = 0; d < 8; d++) begin wa[d] = 0; ha[d] = 0; end
            e = 1'b1;
         end else begin
            if (app_lvl >= 2)     lo_st = 1;
            else if (app_lvl < 1) lo_st = 0;
            if (app_lvl >= 4)     hi_st = 1;
            else if (app_lvl < 3) hi_st = 0;
            win_age  = (lo_st && !hi_st) ? ((win_age < 1_000_000) ? win_age + 1 : win_age) : 0;
            hold_age = app_hold ? 0 : ((hold_age < 1_000_000) ? hold_age + 1 : hold_age);
            for (int d = 7; d > 0; d--) begin wa[d] = wa[d-1]; ha[d] = ha[d-1]; end
            wa[0] = win_age;
            ha[0] = hold_age;
            e = exp_pull_low(wa[KW], ha[KH]);
         end
         check(pg_pull_low, e, cur_tag);
      end
   end

   task automatic run(input int l, input logic h, input int n, input string tag);
      cur_tag = tag;
      lvl  = l;
      hold = h;
      repeat (n) @(negedge clk);
   endtask

   // Check a single expected value at the current sample point.
   task automatic point(input logic exp, input string tag);
      check(pg_pull_low, exp, tag);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      cur_tag = "R1";
      repeat (4) @(negedge clk);
      point(1'b1, "R1");
      rst = 1'b0;

      // R5: clean entry, release exactly LAT edges after first sample
      run(2, 1'b0, LAT - 1, "R5");
      point(1'b1, "R5");
      run(2, 1'b0, 1, "R5");
      point(1'b0, "R5");
      run(2, 1'b0, 20, "R5");

      // R2: fall into 88-92 band stays good; below 88 drops; climb to band stays low
      run(1, 1'b0, 300, "R2");
      point(1'b0, "R2");
      run(0, 1'b0, 10, "R2");
      point(1'b1, "R2");
      run(1, 1'b0, LAT + 50, "R2");
      point(1'b1, "R2");
      run(2, 1'b0, LAT + 10, "R2");
      point(1'b0, "R2");

      // R3: trip high, band 107-110.7 from above stays out, below 107 re-enters
      run(4, 1'b0, 10, "R3");
      point(1'b1, "R3");
      run(3, 1'b0, LAT + 50, "R3");
      point(1'b1, "R3");
      run(2, 1'b0, LAT + 10, "R3");
      point(1'b0, "R3");
      run(3, 1'b0, 200, "R3");
      point(1'b0, "R3");

      // R4: repeated short in-window bursts never qualify
      run(0, 1'b0, 10, "R4");
      for (int i = 0; i < 30; i++) begin
         run(2, 1'b0, DG - 2, "R4");
         run(0, 1'b0, 3, "R4");
      end
      point(1'b1, "R4");

      // R6: one-cycle dropout restarts everything
      run(2, 1'b0, LAT + 10, "R6");
      run(0, 1'b0, 1, "R6");
      run(2, 1'b0, SYNC + 3, "R6");
      point(1'b1, "R6");
      run(2, 1'b0, LAT - 10, "R6");
      point(1'b1, "R6");
      run(2, 1'b0, 20, "R6");
      point(1'b0, "R6");

      // R7 / R8: hold while good, then release
      run(2, 1'b1, SYNC + 1, "R7");
      point(1'b1, "R7");
      run(2, 1'b1, 60, "R7");
      point(1'b1, "R7");
      run(2, 1'b0, SYNC + DLY - 1, "R8");
      point(1'b1, "R8");
      run(2, 1'b0, 1, "R8");
      point(1'b0, "R8");

      // R9: hold released while out of window
      run(0, 1'b1, 40, "R9");
      run(0, 1'b0, 200, "R9");
      point(1'b1, "R9");
      run(2, 1'b0, LAT - 1, "R9");
      point(1'b1, "R9");
      run(2, 1'b0, 1, "R9");
      point(1'b0, "R9");

      // R1: mid-run reset
      cur_tag = "R1";
      rst = 1'b1;
      repeat (3) @(negedge clk);
      point(1'b1, "R1");
      rst = 1'b0;
      run(2, 1'b0, LAT + 5, "R1");

      // Random phases, checked every cycle by the model
      for (int p = 0; p < 45; p++) begin
         int   l = $urandom_range(0, 4);
         logic h = ($urandom_range(0, 6) == 0);
         int   n = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 40)
                                               : $urandom_range(200, 1300);
         run(l, h, n, "R6");
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule